// File: doc/BRIEF.md
# Periodic Signal Presence Detector

This block tells whether a slow periodic signal from outside the chip is actually connected. The raw input has no fixed phase relation to the system clock. It is first passed through a chain of flip-flops clocked by the system clock. Rising edges are then found on the settled samples, never on the raw pin, so an input that changes only in step with the clock is still caught on the next sample.

Each rising edge gives a one-cycle strobe and advances a small wrapping edge counter, which is brought out for debug. A watchdog timer reloads on every edge. The present flag rises on the first edge after reset or after a timeout. It falls when the timer reaches its limit with no edge seen. The design point is a 1 MHz system clock and a 4 kHz input, which gives about 250 cycles between edges against a default limit of 512 cycles. An input stuck at either level therefore reads as absent.

Top module: `sigmon_top`

## Requirements
- R1: The raw input passes through `SYNC_STAGES` (default 2) flip-flops before edge detection. A rising input first sampled at clock k raises `edge_o` in the cycle that follows clock k+1.
- R2: `edge_o` is high for exactly one cycle per rising edge of the input, however long the input then stays high.
- R3: `cnt_o` (`CNT_W` = 4 bits) goes up by one at the clock edge that samples `edge_o` high, and holds otherwise.
- R4: `cnt_o` wraps from 15 to 0, and the wrap has no effect on `present_o`.
- R5: `present_o` goes to 1 at the clock that samples `edge_o` high, including the first edge after reset or after a timeout.
- R6: If an edge is sampled at clock E and none follows, `present_o` stays 1 through clock E+511 and drops to 0 at clock E+512 (`TIMEOUT` = 512). This holds whether the input is stuck high or stuck low.
- R7: An edge sampled at the very clock where the timeout would expire wins: `present_o` stays 1 and the timer reloads.
- R8: While `rst` is high, `present_o`, `cnt_o` and `edge_o` are 0 after the next clock, and the synchronizer is cleared.
- R9: A falling edge of the input gives no strobe and leaves `cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sig_i | input | 1 | Raw external periodic signal, asynchronous |
| edge_o | output | 1 | One-cycle rising-edge strobe |
| present_o | output | 1 | Signal judged connected |
| cnt_o | output | CNT_W | Wrapping count of rising edges, for debug |

## Verification
The edge reload and the timeout expiry can fall on the same clock. To provoke this, the bench places two rising inputs exactly 512 cycles apart, so the second strobe is sampled on the expiring clock. It then requires `present_o` to stay high. The bench repeats the run with a spacing of 513 cycles and requires `present_o` to drop for one cycle before the late edge sets it again. That contrast shows the edge takes priority over the timeout only on the exact colliding cycle.

// File: rtl/sigmon_pkg.sv
package sigmon_pkg;

    // settled sample and its rising-edge flag
    typedef struct packed {
        logic level;
        logic rise;
    } samp_t;

    typedef enum logic {
        LINK_ABSENT  = 1'b0,
        LINK_PRESENT = 1'b1
    } link_e;

    function automatic int timer_w(input int limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/sigmon_sync.sv
module sigmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic safe_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[i] <= 1'b0;
                end else if (i == 0) begin
                    chain_q[i] <= raw_i;
                end else begin
                    chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

    assign safe_o = chain_q[STAGES-1];
endmodule

// File: rtl/sigmon_edge.sv
module sigmon_edge
    import sigmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  safe_i,
    output samp_t samp_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= safe_i;
    end

    always_comb begin
        samp_o.level = safe_i;
        samp_o.rise  = safe_i & ~prev_q;
    end
endmodule

// File: rtl/sigmon_watch.sv
module sigmon_watch
    import sigmon_pkg::*;
#(
    parameter int TIMEOUT = 512
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rise_i,
    output link_e link_o
);
    localparam int TW = timer_w(TIMEOUT);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] timer_q;
    link_e         link_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            link_q  <= LINK_ABSENT;
        end else if (rise_i) begin
            // edge has priority over an expiring timer
            timer_q <= '0;
            link_q  <= LINK_PRESENT;
        end else if (link_q == LINK_PRESENT) begin
            if (timer_q == LAST) begin
                timer_q <= '0;
                link_q  <= LINK_ABSENT;
            end else begin
                timer_q <= timer_q + 1'b1;
            end
        end
    end

    assign link_o = link_q;
endmodule

// File: rtl/sigmon_top.sv
module sigmon_top
    import sigmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT     = 512,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_i,
    output logic             edge_o,
    output logic             present_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic             safe;
    samp_t            samp;
    link_e            link;
    logic [CNT_W-1:0] cnt_q;

    sigmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_i(sig_i), .safe_o(safe)
    );

    sigmon_edge u_edge (
        .clk(clk), .rst(rst), .safe_i(safe), .samp_o(samp)
    );

    sigmon_watch #(.TIMEOUT(TIMEOUT)) u_watch (
        .clk(clk), .rst(rst), .rise_i(samp.rise), .link_o(link)
    );

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (samp.rise) cnt_q <= cnt_q + 1'b1;
    end

    assign edge_o    = samp.rise;
    assign present_o = (link == LINK_PRESENT);
    assign cnt_o     = cnt_q;
endmodule

// File: rtl/sigmon_chk.sv
module sigmon_chk #(
    parameter int TIMEOUT = 512,
    parameter int CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             sig_i,
    input logic             edge_o,
    input logic             present_o,
    input logic [CNT_W-1:0] cnt_o
);
    localparam int IW = $clog2(TIMEOUT) + 1;
    logic [IW-1:0] idle_q;
    logic [1:0]    age_q;

    // cycles since the last sampled edge, saturating
    always_ff @(posedge clk) begin
        if (rst || edge_o)             idle_q <= '0;
        else if (idle_q != IW'(TIMEOUT)) idle_q <= idle_q + 1'b1;
    end

    // cycles since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 1'b1;
    end

    // R1: a strobe needs the raw input high two clocks earlier
    a_r1_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (edge_o && age_q >= 2'd2) |-> $past(sig_i, 2));

    // R2: the strobe lasts one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> !edge_o);

    // R3: the count steps by one on an edge
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> cnt_o == $past(cnt_o) + 1'b1);

    // R3: the count holds without an edge
    a_r3_count_hold: assert property (@(posedge clk) disable iff (rst)
        !edge_o |=> $stable(cnt_o));

    // R5: an edge sets presence
    a_r5_present_set: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> present_o);

    // R6: presence never outlives the timeout window
    a_r6_window: assert property (@(posedge clk) disable iff (rst)
        present_o |-> idle_q < IW'(TIMEOUT));

    // R6: presence falls only without an edge
    a_r6_fall_no_edge: assert property (@(posedge clk) disable iff (rst)
        $fell(present_o) |-> !$past(edge_o));

    // R8: reset clears outputs
    a_r8_reset: assert property (@(posedge clk)
        rst |=> (!present_o && cnt_o == '0 && !edge_o));
endmodule

bind sigmon_top sigmon_chk #(.TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .sig_i(sig_i), .edge_o(edge_o),
    .present_o(present_o), .cnt_o(cnt_o)
);

// File: tb/sigmon_top_tb.sv
module sigmon_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sig = 1'b0;
    logic             edge_o;
    logic             present_o;
    logic [CNT_W-1:0] cnt_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [CNT_W-1:0] model_cnt = '0;
    logic [CNT_W-1:0] exp_q[$];
    bit chk_next = 1'b0;

    sigmon_top #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .sig_i(sig),
        .edge_o(edge_o), .present_o(present_o), .cnt_o(cnt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: raise the input and push the expected count into the scoreboard
    task automatic rise();
        sig = 1'b1;
        model_cnt = model_cnt + 1'b1;
        exp_q.push_back(model_cnt);
    endtask

    // monitor: one negedge after a strobe, compare the count (R3, R4)
    always @(negedge clk) begin
        if (chk_next) begin
            if (exp_q.size() == 0) check("R3 unexpected strobe", 1, 0);
            else check("R3 scoreboard count", cnt_o, exp_q.pop_front());
        end
        chk_next = edge_o && !rst;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R8 present in reset", present_o, 0);
        check("R8 count in reset", cnt_o, 0);
        check("R8 strobe in reset", edge_o, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 / R2 / R5 timing of a single edge
        check("R5 absent before edge", present_o, 0);
        rise();
        @(negedge clk); check("R1 no strobe after one stage", edge_o, 0);
        @(negedge clk); check("R1 strobe after two stages", edge_o, 1);
        @(negedge clk); check("R2 strobe one cycle", edge_o, 0);
        check("R5 present after first edge", present_o, 1);
        repeat (5) @(negedge clk); check("R2 no strobe while high", edge_o, 0);

        // R9 falling edge ignored
        sig = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R9 no strobe on fall", edge_o, 0);
        end
        check("R9 count unchanged on fall", cnt_o, model_cnt);

        // nominal 250-cycle period, 20 edges, crosses the R4 wrap
        for (int p = 0; p < 20; p++) begin
            rise();
            repeat (125) @(negedge clk);
            sig = 1'b0;
            repeat (124) @(negedge clk);
            check("R4 present held over periods and wrap", present_o, 1);
            @(negedge clk);
        end
        check("R4 count after wrap", cnt_o, model_cnt);

        // R6 stuck high
        sig = 1'b0; repeat (600) @(negedge clk);
        check("R6 absent after long low", present_o, 0);
        rise();
        repeat (2) @(negedge clk);
        repeat (512) @(negedge clk);
        check("R6 stuck high last present cycle", present_o, 1);
        @(negedge clk);
        check("R6 stuck high timeout", present_o, 0);

        // R6 stuck low
        sig = 1'b0; repeat (4) @(negedge clk);
        rise();
        repeat (2) @(negedge clk);
        sig = 1'b0;
        repeat (512) @(negedge clk);
        check("R6 stuck low last present cycle", present_o, 1);
        @(negedge clk);
        check("R6 stuck low timeout", present_o, 0);

        // R7 edge on the expiring cycle
        repeat (4) @(negedge clk);
        rise();
        repeat (10) @(negedge clk);
        sig = 1'b0;
        repeat (502) @(negedge clk);
        rise();
        repeat (2) @(negedge clk);
        check("R7 strobe on expiring cycle", edge_o, 1);
        check("R7 present before collision", present_o, 1);
        @(negedge clk);
        check("R7 present kept by colliding edge", present_o, 1);

        // R7 contrast: one cycle late
        repeat (7) @(negedge clk);
        sig = 1'b0;
        repeat (503) @(negedge clk);
        rise();
        repeat (2) @(negedge clk);
        check("R7 late strobe", edge_o, 1);
        check("R7 lapsed one cycle early", present_o, 0);
        @(negedge clk);
        check("R7 restored by late edge", present_o, 1);
        sig = 1'b0;

        repeat (5) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule